// File: doc/BRIEF.md
# Montgomery modular exponentiation sequencer

This block computes A^E mod M for an odd modulus M. It does not multiply anything itself. It drives an external Montgomery multiplier through a request/response handshake, and that multiplier returns X·Y·R⁻¹ mod M with R = 2^NBITS. The operands it hands back may lie anywhere below 2M, provided the modulus stays below R/4.

A start strobe captures four operands:
- the base,
- the exponent,
- the modulus,
- the precomputed constant R² mod M.

The sequencer then works in three phases:
1. **Entry.** It moves the base into the Montgomery domain, then does the same for the integer 1. The second result seeds the accumulator, so the leading exponent bit needs no special handling.
2. **Scan.** It reads the exponent from its most significant bit down. For every bit it squares the accumulator, and for every set bit it then multiplies by the converted base.
3. **Exit.** One multiply by 1 takes the result back out of the Montgomery domain. A last conditional subtraction brings it below M.

Top module: `modexp_seq`

## Requirements
- R1: After reset, done_o is 0, mm_start_o is 0 and result_o is 0.
- R2: The first multiply request of a run carries (x = base, y = R² mod M). The second carries (x = 1, y = R² mod M), and its product becomes the accumulator.
- R3: Exponent bits are taken from bit EBITS-1 down to bit 0. Each bit issues a square request with x = y = accumulator. When the bit is 1, a request (x = accumulator, y = converted base) follows the square.
- R4: The last request of a run carries (x = accumulator, y = 1).
- R5: A run issues exactly 3 + EBITS + popcount(E) multiply requests.
- R6: The result equals A^E mod M and is strictly below M, including when the multiplier returns a value in [M, 2M).
- R7: An exponent of zero yields a result of 1.
- R8: mm_start_o is a one-cycle pulse. No new request is issued until mm_done_i has answered the previous one.
- R9: Operands are captured at start. A start strobe, or a change of the operand inputs, while a run is in progress has no effect on that run.
- R10: done_o is a one-cycle pulse in the cycle after the final mm_done_i. result_o holds its value until the next run completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| base_i | input | NBITS | Base A, below 2M |
| exp_i | input | EBITS | Exponent E |
| mod_i | input | NBITS | Odd modulus M, below 2^(NBITS-2) |
| r2_i | input | NBITS | R² mod M |
| mm_start_o | output | 1 | Multiply request pulse |
| mm_x_o | output | NBITS | Multiplier first operand |
| mm_y_o | output | NBITS | Multiplier second operand |
| mm_m_o | output | NBITS | Modulus for the multiplier |
| mm_done_i | input | 1 | Multiply response pulse |
| mm_z_i | input | NBITS | Multiply result, valid with mm_done_i |
| result_o | output | NBITS | A^E mod M |
| done_o | output | 1 | Completion pulse |

## Verification
The hardest case to reach is the final conditional subtraction. It is exercised only when the multiplier hands back an unreduced value in [M, 2M). The bench's behavioural multiplier is a bit-serial Montgomery loop with no closing subtraction, so it returns such values whenever they arise. Every intermediate request is compared against a trace that the bench computes independently. The response latency varies from request to request. This exposes any request issued before the previous answer, and any strobe accepted while busy.

// File: rtl/modexp_pkg.sv
package modexp_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CVB,   // base into Montgomery domain
    PH_CV1,   // integer 1 into Montgomery domain
    PH_SQR,   // square accumulator
    PH_MUL,   // multiply accumulator by base
    PH_OUT    // back to ordinary integer
  } phase_t;

  // Bring a value in [0, 2M) below M.
  function automatic logic [63:0] below_mod(input logic [63:0] z, input logic [63:0] m);
    return (z >= m) ? (z - m) : z;
  endfunction

endpackage

// File: rtl/modexp_bitscan.sv
module modexp_bitscan #(
  parameter int EBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             shift,
  input  logic [EBITS-1:0] exp_i,
  output logic             cur_bit,
  output logic             last_bit
);
  localparam int CW = (EBITS > 1) ? $clog2(EBITS) : 1;
  localparam logic [CW-1:0] TOP = CW'(EBITS - 1);

  logic [EBITS-1:0] sh_q;
  logic [CW-1:0]    left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (load) begin
      sh_q   <= exp_i;
      left_q <= TOP;
    end else if (shift) begin
      sh_q   <= sh_q << 1;
      left_q <= left_q - 1'b1;
    end
  end

  assign cur_bit  = sh_q[EBITS-1];
  assign last_bit = (left_q == '0);
endmodule

// File: rtl/modexp_ctrl.sv
module modexp_ctrl
  import modexp_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start_i,
  input  logic   mm_done_i,
  input  logic   cur_bit,
  input  logic   last_bit,
  output phase_t phase_o,
  output logic   issued_o,
  output logic   mm_start_o,
  output logic   load_o,
  output logic   take_o,
  output logic   shift_o,
  output logic   finish_o
);
  phase_t phase_q, phase_d;
  logic   issued_q;

  assign load_o     = (phase_q == PH_IDLE) && start_i;
  assign mm_start_o = (phase_q != PH_IDLE) && !issued_q;
  assign take_o     = issued_q && mm_done_i;
  assign finish_o   = take_o && (phase_q == PH_OUT);
  assign shift_o    = take_o && !last_bit &&
                      (((phase_q == PH_SQR) && !cur_bit) || (phase_q == PH_MUL));

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_CVB:  phase_d = PH_CV1;
      PH_CV1:  phase_d = PH_SQR;
      PH_SQR:  phase_d = cur_bit ? PH_MUL : (last_bit ? PH_OUT : PH_SQR);
      PH_MUL:  phase_d = last_bit ? PH_OUT : PH_SQR;
      PH_OUT:  phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      issued_q <= 1'b0;
    end else if (load_o) begin
      phase_q  <= PH_CVB;
      issued_q <= 1'b0;
    end else if (mm_start_o) begin
      issued_q <= 1'b1;
    end else if (take_o) begin
      issued_q <= 1'b0;
      phase_q  <= phase_d;
    end
  end

  assign phase_o  = phase_q;
  assign issued_o = issued_q;
endmodule

// File: rtl/modexp_opsel.sv
module modexp_opsel
  import modexp_pkg::*;
#(
  parameter int NBITS = 16
) (
  input  phase_t           phase,
  input  logic [NBITS-1:0] base_q,
  input  logic [NBITS-1:0] r2_q,
  input  logic [NBITS-1:0] acc_q,
  input  logic [NBITS-1:0] basem_q,
  output logic [NBITS-1:0] x_o,
  output logic [NBITS-1:0] y_o
);
  localparam logic [NBITS-1:0] ONE = NBITS'(1);

  always_comb begin
    x_o = '0;
    y_o = '0;
    case (phase)
      PH_CVB:  begin x_o = base_q; y_o = r2_q;    end
      PH_CV1:  begin x_o = ONE;    y_o = r2_q;    end
      PH_SQR:  begin x_o = acc_q;  y_o = acc_q;   end
      PH_MUL:  begin x_o = acc_q;  y_o = basem_q; end
      PH_OUT:  begin x_o = acc_q;  y_o = ONE;     end
      default: begin x_o = '0;     y_o = '0;      end
    endcase
  end
endmodule

// File: rtl/modexp_seq.sv
module modexp_seq
  import modexp_pkg::*;
#(
  parameter int NBITS = 16,
  parameter int EBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [NBITS-1:0] base_i,
  input  logic [EBITS-1:0] exp_i,
  input  logic [NBITS-1:0] mod_i,
  input  logic [NBITS-1:0] r2_i,
  output logic             mm_start_o,
  output logic [NBITS-1:0] mm_x_o,
  output logic [NBITS-1:0] mm_y_o,
  output logic [NBITS-1:0] mm_m_o,
  input  logic             mm_done_i,
  input  logic [NBITS-1:0] mm_z_i,
  output logic [NBITS-1:0] result_o,
  output logic             done_o
);
  localparam int PADW = 64 - NBITS;

  phase_t           phase;
  logic             issued, load, take, shift, finish, cur_bit, last_bit;
  logic [NBITS-1:0] base_q, mod_q, r2_q, acc_q, basem_q;
  logic [63:0]      fixed_w;

  modexp_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mm_done_i(mm_done_i),
    .cur_bit(cur_bit), .last_bit(last_bit), .phase_o(phase), .issued_o(issued),
    .mm_start_o(mm_start_o), .load_o(load), .take_o(take), .shift_o(shift),
    .finish_o(finish)
  );

  modexp_bitscan #(.EBITS(EBITS)) u_scan (
    .clk(clk), .rst_n(rst_n), .load(load), .shift(shift), .exp_i(exp_i),
    .cur_bit(cur_bit), .last_bit(last_bit)
  );

  modexp_opsel #(.NBITS(NBITS)) u_opsel (
    .phase(phase), .base_q(base_q), .r2_q(r2_q), .acc_q(acc_q),
    .basem_q(basem_q), .x_o(mm_x_o), .y_o(mm_y_o)
  );

  assign fixed_w = below_mod({{PADW{1'b0}}, mm_z_i}, {{PADW{1'b0}}, mod_q});
  assign mm_m_o  = mod_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      mod_q    <= '0;
      r2_q     <= '0;
      acc_q    <= '0;
      basem_q  <= '0;
      result_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= finish;
      if (load) begin
        base_q <= base_i;
        mod_q  <= mod_i;
        r2_q   <= r2_i;
      end
      if (take && phase == PH_CVB) basem_q <= mm_z_i;
      if (take && (phase == PH_CV1 || phase == PH_SQR || phase == PH_MUL)) acc_q <= mm_z_i;
      if (finish) result_o <= fixed_w[NBITS-1:0];
    end
  end
endmodule

// File: rtl/modexp_seq_chk.sv
module modexp_seq_chk
  import modexp_pkg::*;
#(
  parameter int NBITS = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             mm_start_o,
  input logic             mm_done_i,
  input logic [NBITS-1:0] mm_x_o,
  input logic [NBITS-1:0] mm_y_o,
  input logic [NBITS-1:0] result_o,
  input logic [NBITS-1:0] mod_q,
  input logic             done_o,
  input phase_t           phase
);
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mm_start_o |=> !mm_start_o); // R8
  AST_REQ_AFTER_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    mm_start_o |-> ($past(mm_done_i) || $past(start_i))); // R8
  AST_SQUARE_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_start_o && phase == PH_SQR) |-> (mm_x_o == mm_y_o)); // R3
  AST_EXIT_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_start_o && phase == PH_OUT) |-> (mm_y_o == NBITS'(1))); // R4
  AST_RESULT_BELOW_MOD: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (result_o < mod_q)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R10
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o)); // R10
endmodule

bind modexp_seq modexp_seq_chk #(.NBITS(NBITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .mm_start_o(mm_start_o),
  .mm_done_i(mm_done_i), .mm_x_o(mm_x_o), .mm_y_o(mm_y_o),
  .result_o(result_o), .mod_q(mod_q), .done_o(done_o), .phase(phase)
);

// File: tb/modexp_seq_test.sv
module modexp_seq_test;
  localparam int NB = 16;
  localparam int EB = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [NB-1:0] base_i = '0, mod_i = '0, r2_i = '0, mm_z_i = '0;
  logic [EB-1:0] exp_i = '0;
  logic          mm_done_i = 1'b0;
  logic          mm_start_o, done_o;
  logic [NB-1:0] mm_x_o, mm_y_o, mm_m_o, result_o;

  int errors = 0, checks = 0, nreq = 0, overlap = 0;
  longint log_x[0:31];
  longint log_y[0:31];

  always #10 clk = ~clk;

  modexp_seq #(.NBITS(NB), .EBITS(EB)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i), .exp_i(exp_i),
    .mod_i(mod_i), .r2_i(r2_i), .mm_start_o(mm_start_o), .mm_x_o(mm_x_o),
    .mm_y_o(mm_y_o), .mm_m_o(mm_m_o), .mm_done_i(mm_done_i), .mm_z_i(mm_z_i),
    .result_o(result_o), .done_o(done_o)
  );

  // bit-serial Montgomery product, no closing subtraction: result in [0, 2M)
  function automatic longint mont(longint x, longint y, longint m);
    longint z = 0;
    for (int i = 0; i < NB; i++) begin
      if (x[i]) z = z + y;
      if (z[0]) z = z + m;
      z = z >> 1;
    end
    return z;
  endfunction

  function automatic longint ref_pow(longint a, longint e, longint m);
    longint r = 1 % m;
    for (int i = EB - 1; i >= 0; i--) begin
      r = (r * r) % m;
      if (e[i]) r = (r * (a % m)) % m;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural multiplier with varying latency
  initial begin
    longint zval;
    forever begin
      if (mm_start_o === 1'b1) begin
        if (nreq < 32) begin
          log_x[nreq] = longint'(mm_x_o);
          log_y[nreq] = longint'(mm_y_o);
        end
        zval = mont(longint'(mm_x_o), longint'(mm_y_o), longint'(mm_m_o));
        nreq++;
        for (int k = 0; k < 1 + (nreq % 3); k++) begin
          @(negedge clk);
          if (mm_start_o) overlap++;
        end
        mm_z_i = zval[NB-1:0];
        mm_done_i = 1'b1;
        @(negedge clk);
        mm_done_i = 1'b0;
      end else @(negedge clk);
    end
  end

  task automatic launch(input longint a, input longint e, input longint m);
    @(negedge clk);
    base_i = a[NB-1:0]; exp_i = e[EB-1:0]; mod_i = m[NB-1:0];
    r2_i = NB'((64'd1 << (2 * NB)) % m);
    nreq = 0; overlap = 0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done_o && n < 2000) begin @(negedge clk); n++; end
  endtask

  // full run with trace check against an independently computed sequence
  task automatic t_run(input longint a, input longint e, input longint m);
    longint r2, bm, acc, exp_res;
    int idx, bad, ones;
    r2 = (64'd1 << (2 * NB)) % m;
    launch(a, e, m);
    wait_done();
    exp_res = ref_pow(a, e, m);
    chk(done_o == 1'b1, "R10 done seen", longint'(done_o), 1);
    chk(longint'(result_o) == exp_res, "R6 result", longint'(result_o), exp_res);
    if (e == 0) chk(longint'(result_o) == 1, "R7 zero exponent", longint'(result_o), 1);
    @(negedge clk);
    chk(done_o == 1'b0, "R10 done one cycle", longint'(done_o), 0);
    chk(longint'(result_o) == exp_res, "R10 result held", longint'(result_o), exp_res);
    chk(log_x[0] == a && log_y[0] == r2, "R2 base conversion", log_x[0], a);
    chk(log_x[1] == 1 && log_y[1] == r2, "R2 one conversion", log_x[1], 1);
    bm  = mont(a, r2, m);
    acc = mont(1, r2, m);
    idx = 2; bad = 0; ones = 0;
    for (int i = EB - 1; i >= 0; i--) begin
      if (log_x[idx] != acc || log_y[idx] != acc) bad++;
      acc = mont(acc, acc, m); idx++;
      if (e[i]) begin
        ones++;
        if (log_x[idx] != acc || log_y[idx] != bm) bad++;
        acc = mont(acc, bm, m); idx++;
      end
    end
    chk(bad == 0, "R3 square/multiply trace", bad, 0);
    chk(log_x[idx] == acc && log_y[idx] == 1, "R4 exit conversion", log_y[idx], 1);
    chk(nreq == 3 + EB + ones, "R5 request count", nreq, 3 + EB + ones);
    chk(overlap == 0, "R8 one request at a time", overlap, 0);
  endtask

  task automatic t_reset();
    chk(done_o == 1'b0 && mm_start_o == 1'b0, "R1 reset outputs", longint'(done_o), 0);
    chk(result_o == '0, "R1 reset result", longint'(result_o), 0);
  endtask

  task automatic t_busy_start();
    longint exp_res = ref_pow(7, 8'hA5, 12347);
    launch(7, 8'hA5, 12347);
    repeat (6) @(negedge clk);
    base_i = 16'd99; exp_i = 8'h3C; mod_i = 16'd3001; r2_i = 16'd5;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done();
    chk(longint'(result_o) == exp_res, "R9 start while busy ignored", longint'(result_o), exp_res);
    chk(nreq == 3 + EB + 4, "R9 no extra requests", nreq, 3 + EB + 4);
    chk(overlap == 0, "R8 overlap under busy start", overlap, 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_run(5, 8'b1011_0010, 9973);
    t_run(1234, 8'hFF, 16381);
    t_run(3, 8'h01, 11);
    t_run(77, 8'h00, 4093);
    t_run(2, 8'h80, 3);
    t_run(15000, 8'h5A, 15013);
    t_busy_start();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule